// File: doc/BRIEF.md
# SPI Slave Command Frame Decoder

This block sits behind an SPI slave byte shifter and interprets a byte-oriented register-access protocol. The first byte of each chip-select window is an opcode. The opcode fixes how many field bytes follow and how they are laid out: a 3-byte or 2-byte address, an optional 2- or 3-byte transfer length, and an optional 4-byte write word. All multi-byte fields arrive most significant byte first. When the CRC mode input is high at the opcode byte, one CRC7 byte follows the fields. The decoder checks it against its own CRC7, which covers the opcode and every field byte.

The link is full duplex. The decoder presents `tx_byte`, the byte the shifter sends in the next byte slot, and updates it on every received byte. The reply starts in the slot right after the last command byte. It sends the opcode again, then a status byte. Reads also return a header byte, the register word and, in CRC mode, a CRC-16 of that word. A decoded register command becomes a one-cycle request on a simple register port. A decoded block-transfer command becomes a one-cycle request that carries the start address, the length and the direction.

The block data of a block transfer is not streamed by this decoder. Deasserting chip select discards any partial frame and returns the decoder to idle.

Top module: `sfd_cmd_decoder`

## Requirements
- R1: After reset `tx_byte` is 0x00 and `reg_req` and `dma_req` are low.
- R2: The number of field bytes after the opcode is 5 for 0xC1/0xC2, 6 for 0xC7/0xC8/0xC3, 7 for 0xC9, and 3 for every other opcode. While a command is being received `tx_byte` is 0x00. After the last command byte (field byte, or CRC byte in CRC mode) `tx_byte` becomes the received opcode.
- R3: A successful frame's reply is opcode, then status 0x00. For anything other than a read, every later slot is 0x00.
- R4: For 0xCA and 0xC4 the reply after status 0x00 is header 0xF0, then the four bytes of `reg_rdata` least significant byte first. `reg_rdata` is sampled in the cycle `reg_req` is high.
- R5: In CRC mode a read reply appends two bytes after the data: CRC-16 (polynomial 0x1021, initial value 0x0000, bits processed MSB first) over the four data bytes in the order sent, high byte first.
- R6: The CRC byte is compared on bits 7:1 against the CRC7 (polynomial x^7+x^3+1, register preset to all ones, bits MSB first) of the opcode and field bytes. Bit 0 of the CRC byte is ignored.
- R7: An opcode outside the set 0xC1–0xC9, 0xCA, 0xCF, or a CRC mismatch, gives status 0x01. The reply then ends after the status byte, and neither request fires.
- R8: 0xC9/0xCA (single register) and 0xC3/0xC4 (internal register) give one `reg_req` pulse in the cycle after the last command byte, with the following fields:
  - `reg_we` is high for 0xC9 and 0xC3.
  - `reg_internal` is high for 0xC3 and 0xC4.
  - `reg_addr` is the 3-byte address for single commands. For internal commands it is {9'b0, 15 low bits of the 2-byte address}.
  - `reg_clockless` is bit 7 of the first internal address byte.
  - `reg_wdata` is the big-endian write word.
  - 0xC4 carries one pad byte after its address.
- R9: 0xC1/0xC2 and 0xC7/0xC8 give one `dma_req` pulse in the cycle after the last command byte, with the following fields:
  - `dma_addr` is the 3-byte address.
  - `dma_len` is the 2-byte length zero-extended (0xC1/0xC2) or the 3-byte length (0xC7/0xC8).
  - `dma_we` is high for 0xC1/0xC7.
- R10: 0xC5, 0xC6 and 0xCF take 3 ignored field bytes, reply opcode and status 0x00, and issue no request.
- R11: A cycle with `cs_active` low forces `tx_byte` to 0x00 on the next edge, discards a partial frame, and makes the next received byte an opcode.
- R12: `crc_en` is sampled with the opcode byte and holds for the whole frame.
- R13: After the reply, further received bytes yield 0x00 and no request until chip select is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | High while the SPI chip select is asserted (synchronous) |
| rx_valid | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte | input | 8 | Received byte |
| crc_en | input | 1 | CRC mode select, sampled at the opcode |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| reg_req | output | 1 | Register access request pulse |
| reg_we | output | 1 | Register request is a write |
| reg_internal | output | 1 | Register request targets the internal space |
| reg_clockless | output | 1 | Internal access flagged clockless |
| reg_addr | output | 24 | Register address |
| reg_wdata | output | 32 | Register write word |
| reg_rdata | input | 32 | Register read word, valid while reg_req is high |
| dma_req | output | 1 | Block-transfer request pulse |
| dma_we | output | 1 | Block transfer is a write |
| dma_addr | output | 24 | Block-transfer start address |
| dma_len | output | 24 | Block-transfer length in bytes |

## Verification
A wrong field-count or opcode state shows at once. The opcode echo appears a slot early or late, or a stray non-zero byte appears while the command is still arriving. Either is visible one cycle after the byte that misled the decoder. A corrupted CRC7 or CRC-16 state stays hidden until the end of the frame, where it turns into a wrong status byte, a missing request or wrong trailing reply bytes. The reference model therefore predicts `tx_byte` and both request strobes for every cycle. Stale state after a chip-select drop is exposed by starting a fresh frame right after a truncated one.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 24;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 24;
  localparam int BODY_MAX  = 7;
  localparam int SHIFT_W   = BODY_MAX * BYTE_W;
  localparam int CNT_W     = $clog2(BODY_MAX + 1);
  localparam int IDX_W     = 4;
  localparam int CRC7_W    = 7;
  localparam int CRC16_W   = 16;

  localparam logic [7:0] OP_BLK_WR  = 8'hC1;
  localparam logic [7:0] OP_BLK_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_STOP    = 8'hC5;
  localparam logic [7:0] OP_AGAIN   = 8'hC6;
  localparam logic [7:0] OP_XBLK_WR = 8'hC7;
  localparam logic [7:0] OP_XBLK_RD = 8'hC8;
  localparam logic [7:0] OP_REG_WR  = 8'hC9;
  localparam logic [7:0] OP_REG_RD  = 8'hCA;
  localparam logic [7:0] OP_SOFTRST = 8'hCF;

  localparam logic [7:0] STATUS_OK   = 8'h00;
  localparam logic [7:0] STATUS_FAIL = 8'h01;

  function automatic logic [CNT_W-1:0] body_len(input logic [7:0] op);
    case (op)
      OP_BLK_WR, OP_BLK_RD:              body_len = CNT_W'(5);
      OP_XBLK_WR, OP_XBLK_RD, OP_INT_WR: body_len = CNT_W'(6);
      OP_REG_WR:                         body_len = CNT_W'(7);
      default:                           body_len = CNT_W'(3);
    endcase
  endfunction

  function automatic logic op_known(input logic [7:0] op);
    op_known = (op >= OP_BLK_WR && op <= OP_REG_RD) || (op == OP_SOFTRST);
  endfunction

  function automatic logic [CRC7_W-1:0] crc7_step(input logic [CRC7_W-1:0] c_in,
                                                  input logic [7:0] b);
    logic [CRC7_W-1:0] c;
    logic fb;
    c = c_in;
    for (int k = 7; k >= 0; k--) begin
      fb = c[CRC7_W-1] ^ b[k];
      c  = {c[CRC7_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    crc7_step = c;
  endfunction

  // CRC-16 over the word bytes in transmit order (least significant first).
  function automatic logic [CRC16_W-1:0] crc16_word(input logic [WORD_W-1:0] w);
    logic [CRC16_W-1:0] c;
    logic [7:0] b;
    logic fb;
    c = '0;
    for (int i = 0; i < WORD_W / 8; i++) begin
      b = w[8*i +: 8];
      for (int k = 7; k >= 0; k--) begin
        fb = c[CRC16_W-1] ^ b[k];
        c  = {c[CRC16_W-2:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    end
    crc16_word = c;
  endfunction
endpackage

// File: rtl/sfd_crc7_acc.sv
module sfd_crc7_acc
  import sfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              first,
  input  logic [7:0]        data,
  output logic [CRC7_W-1:0] crc_q
);
  localparam logic [CRC7_W-1:0] SEED = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= SEED;
    else if (step) crc_q <= crc7_step(first ? SEED : crc_q, data);
  end
endmodule

// File: rtl/sfd_field_shift.sv
module sfd_field_shift
  import sfd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift,
  input  logic [7:0]         data,
  output logic [SHIFT_W-1:0] sh_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (clr)   sh_q <= '0;
    else if (shift) sh_q <= {sh_q[SHIFT_W-9:0], data};
  end
endmodule

// File: rtl/sfd_resp_seq.sv
module sfd_resp_seq
  import sfd_pkg::*;
#(
  parameter logic [7:0] HDR_BYTE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  input  logic [7:0]        op,
  input  logic [7:0]        status,
  input  logic              is_read,
  input  logic              crc_on,
  input  logic              adv,
  input  logic              cap,
  input  logic [WORD_W-1:0] rdata,
  output logic [7:0]        tx_byte
);
  localparam logic [IDX_W-1:0] LEN_SHORT = IDX_W'(2);
  localparam logic [IDX_W-1:0] LEN_READ  = IDX_W'(3 + WORD_W / 8);
  localparam logic [IDX_W-1:0] LEN_RCRC  = IDX_W'(5 + WORD_W / 8);

  logic [7:0]         st_q;
  logic [WORD_W-1:0]  word_q;
  logic [IDX_W-1:0]   idx_q, len_q;
  logic               act_q;
  logic [CRC16_W-1:0] word_crc;
  logic [7:0]         next_byte;

  assign word_crc = crc16_word(word_q);

  always_comb begin
    next_byte = 8'h00;
    case (idx_q)
      IDX_W'(1): next_byte = st_q;
      IDX_W'(2): next_byte = HDR_BYTE;
      IDX_W'(3): next_byte = word_q[7:0];
      IDX_W'(4): next_byte = word_q[15:8];
      IDX_W'(5): next_byte = word_q[23:16];
      IDX_W'(6): next_byte = word_q[31:24];
      IDX_W'(7): next_byte = word_crc[15:8];
      IDX_W'(8): next_byte = word_crc[7:0];
      default:   next_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= '0;
    else if (cap) word_q <= rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= 8'h00;
      st_q    <= 8'h00;
      idx_q   <= '0;
      len_q   <= '0;
      act_q   <= 1'b0;
    end else if (clear) begin
      tx_byte <= 8'h00;
      idx_q   <= '0;
      act_q   <= 1'b0;
    end else if (start) begin
      tx_byte <= op;
      st_q    <= status;
      idx_q   <= IDX_W'(1);
      len_q   <= !is_read ? LEN_SHORT : (crc_on ? LEN_RCRC : LEN_READ);
      act_q   <= 1'b1;
    end else if (act_q && adv) begin
      if (idx_q == len_q) begin
        tx_byte <= 8'h00;
        act_q   <= 1'b0;
      end else begin
        tx_byte <= next_byte;
        idx_q   <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/sfd_cmd_decoder.sv
module sfd_cmd_decoder
  import sfd_pkg::*;
#(
  parameter logic [7:0] HDR_BYTE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              crc_en,
  output logic [7:0]        tx_byte,
  output logic              reg_req,
  output logic              reg_we,
  output logic              reg_internal,
  output logic              reg_clockless,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              dma_req,
  output logic              dma_we,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len
);
  typedef enum logic [1:0] {S_IDLE, S_BODY, S_CRC, S_HOLD} state_e;

  state_e             state_q;
  logic [7:0]         op_q;
  logic [CNT_W-1:0]   need_q, cnt_q;
  logic               crc_on_q;
  logic [CRC7_W-1:0]  crc_q;
  logic [SHIFT_W-1:0] sh_q, sh_view;

  // Named internal events, also observed by the bound checker.
  logic take, last_body, crc_bad, frame_done, frame_err, in_cmd;
  logic is_reg, is_blk, is_rd;

  assign take       = cs_active && rx_valid;
  assign last_body  = (state_q == S_BODY) && take && (CNT_W'(cnt_q + 1'b1) == need_q);
  assign crc_bad    = (state_q == S_CRC) && (rx_byte[7:1] != crc_q);
  assign frame_done = (last_body && !crc_on_q) || ((state_q == S_CRC) && take);
  assign frame_err  = frame_done && (!op_known(op_q) || crc_bad);
  assign in_cmd     = (state_q != S_HOLD);

  assign is_reg = (op_q == OP_REG_WR) || (op_q == OP_REG_RD) ||
                  (op_q == OP_INT_WR) || (op_q == OP_INT_RD);
  assign is_blk = (op_q == OP_BLK_WR) || (op_q == OP_BLK_RD) ||
                  (op_q == OP_XBLK_WR) || (op_q == OP_XBLK_RD);
  assign is_rd  = (op_q == OP_REG_RD) || (op_q == OP_INT_RD);

  // Field bytes including the byte arriving now when it is the last field byte.
  assign sh_view = (state_q == S_CRC) ? sh_q : {sh_q[SHIFT_W-9:0], rx_byte};

  sfd_crc7_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (take && (state_q == S_IDLE || state_q == S_BODY)),
    .first (state_q == S_IDLE),
    .data  (rx_byte),
    .crc_q (crc_q)
  );

  sfd_field_shift u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (take && state_q == S_IDLE),
    .shift (take && state_q == S_BODY),
    .data  (rx_byte),
    .sh_q  (sh_q)
  );

  sfd_resp_seq #(.HDR_BYTE(HDR_BYTE)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!cs_active),
    .start   (frame_done),
    .op      (op_q),
    .status  (frame_err ? STATUS_FAIL : STATUS_OK),
    .is_read (!frame_err && is_rd),
    .crc_on  (crc_on_q),
    .adv     (take),
    .cap     (reg_req && !reg_we),
    .rdata   (reg_rdata),
    .tx_byte (tx_byte)
  );

  // Field decode by frame layout.
  logic [ADDR_W-1:0] f_addr, f_raddr;
  logic [LEN_W-1:0]  f_len;
  logic [WORD_W-1:0] f_data;
  logic [15:0]       f_a16;

  always_comb begin
    f_addr = sh_view[23:0];
    f_len  = '0;
    f_data = sh_view[31:0];
    f_a16  = sh_view[23:8];
    case (op_q)
      OP_REG_WR:              f_addr = sh_view[55:32];
      OP_BLK_WR, OP_BLK_RD: begin
        f_addr = sh_view[39:16];
        f_len  = LEN_W'(sh_view[15:0]);
      end
      OP_XBLK_WR, OP_XBLK_RD: begin
        f_addr = sh_view[47:24];
        f_len  = sh_view[23:0];
      end
      OP_INT_WR:              f_a16 = sh_view[47:32];
      default: ;
    endcase
    f_raddr = ((op_q == OP_INT_WR) || (op_q == OP_INT_RD)) ?
              ADDR_W'(f_a16[14:0]) : f_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= '0;
      need_q   <= '0;
      cnt_q    <= '0;
      crc_on_q <= 1'b0;
    end else if (!cs_active) begin
      state_q  <= S_IDLE;
    end else if (rx_valid) begin
      case (state_q)
        S_IDLE: begin
          op_q     <= rx_byte;
          need_q   <= body_len(rx_byte);
          cnt_q    <= '0;
          crc_on_q <= crc_en;
          state_q  <= S_BODY;
        end
        S_BODY: begin
          cnt_q <= CNT_W'(cnt_q + 1'b1);
          if (last_body) state_q <= crc_on_q ? S_CRC : S_HOLD;
        end
        S_CRC:   state_q <= S_HOLD;
        default: state_q <= S_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_req       <= 1'b0;
      reg_we        <= 1'b0;
      reg_internal  <= 1'b0;
      reg_clockless <= 1'b0;
      reg_addr      <= '0;
      reg_wdata     <= '0;
      dma_req       <= 1'b0;
      dma_we        <= 1'b0;
      dma_addr      <= '0;
      dma_len       <= '0;
    end else begin
      reg_req <= frame_done && !frame_err && is_reg;
      dma_req <= frame_done && !frame_err && is_blk;
      if (frame_done) begin
        reg_we        <= (op_q == OP_REG_WR) || (op_q == OP_INT_WR);
        reg_internal  <= (op_q == OP_INT_WR) || (op_q == OP_INT_RD);
        reg_clockless <= ((op_q == OP_INT_WR) || (op_q == OP_INT_RD)) && f_a16[15];
        reg_addr      <= f_raddr;
        reg_wdata     <= f_data;
        dma_we        <= (op_q == OP_BLK_WR) || (op_q == OP_XBLK_WR);
        dma_addr      <= f_addr;
        dma_len       <= f_len;
      end
    end
  end
endmodule

// File: rtl/sfd_cmd_decoder_chk.sv
module sfd_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_active,
  input logic [7:0] tx_byte,
  input logic       reg_req,
  input logic       dma_req,
  input logic       frame_done,
  input logic       frame_err,
  input logic       in_cmd
);
  AST_ONE_REQ_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && dma_req)); // R8

  AST_REG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !reg_req); // R8

  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req); // R9

  AST_REQ_FROM_GOOD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_err) |=> $onehot0({reg_req, dma_req})); // R9

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> (!reg_req && !dma_req)); // R7

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (tx_byte == 8'h00 && !reg_req && !dma_req)); // R11

  AST_CMD_TX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_cmd |-> (tx_byte == 8'h00)); // R2
endmodule

bind sfd_cmd_decoder sfd_cmd_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_active  (cs_active),
  .tx_byte    (tx_byte),
  .reg_req    (reg_req),
  .dma_req    (dma_req),
  .frame_done (frame_done),
  .frame_err  (frame_err),
  .in_cmd     (in_cmd)
);

// File: tb/sim_sfd_cmd_decoder.sv
module sim_sfd_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_active = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        crc_en = 1'b0;
  logic [7:0]  tx_byte;
  logic        reg_req, reg_we, reg_internal, reg_clockless;
  logic [23:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = 32'h0;
  logic        dma_req, dma_we;
  logic [23:0] dma_addr, dma_len;

  always #5 clk = ~clk;

  sfd_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .crc_en(crc_en), .tx_byte(tx_byte),
    .reg_req(reg_req), .reg_we(reg_we), .reg_internal(reg_internal),
    .reg_clockless(reg_clockless), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_req(dma_req), .dma_we(dma_we),
    .dma_addr(dma_addr), .dma_len(dma_len)
  );

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit    mon_on = 1'b0;

  // Reference model state
  logic [7:0]  fr_q[$];
  logic [7:0]  rs_q[$];
  int          m_phase = 0;   // 0 wait opcode, 1 command, 2 reply/parked
  bit          m_crc;
  int          m_need;
  logic [7:0]  exp_tx = 8'h00;
  bit          exp_rreq = 0, exp_dreq = 0;
  logic [58:0] exp_rfld;
  logic [48:0] exp_dfld;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int fields_of(input logic [7:0] op);
    if (op == 8'hC1 || op == 8'hC2) return 5;
    if (op == 8'hC7 || op == 8'hC8 || op == 8'hC3) return 6;
    if (op == 8'hC9) return 7;
    return 3;
  endfunction

  function automatic logic [7:0] ref_crc7(input logic [7:0] q[$], input int n);
    logic [7:0] c = 8'hFE;
    for (int i = 0; i < n; i++) begin
      c = c ^ q[i];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h12) : (c << 1);
    end
    return c & 8'hFE;
  endfunction

  function automatic logic [15:0] ref_crc16(input logic [31:0] w);
    int c = 0;
    for (int i = 0; i < 4; i++) begin
      c = c ^ (int'((w >> (8 * i)) & 32'hFF) << 8);
      for (int k = 0; k < 8; k++)
        c = ((c & 16'h8000) != 0) ? (((c << 1) ^ 16'h1021) & 16'hFFFF) : ((c << 1) & 16'hFFFF);
    end
    return 16'(c);
  endfunction

  task automatic model_finish();
    logic [7:0] op = fr_q[0];
    bit known = (op >= 8'hC1 && op <= 8'hCA) || op == 8'hCF;
    bit ok = known && (!m_crc || (fr_q[m_need + 1][7:1] == ref_crc7(fr_q, m_need + 1)[7:1]));
    bit is_int = (op == 8'hC3 || op == 8'hC4);
    bit is_wr  = (op == 8'hC3 || op == 8'hC9);
    logic [23:0] ra;
    logic [15:0] cc;
    if (is_int) ra = {9'b0, fr_q[1][6:0], fr_q[2]};
    else        ra = {fr_q[1], fr_q[2], fr_q[3]};
    rs_q.delete();
    rs_q.push_back(op);
    rs_q.push_back(ok ? 8'h00 : 8'h01);
    if (ok && (op == 8'hC3 || op == 8'hC4 || op == 8'hC9 || op == 8'hCA)) begin
      exp_rreq = 1;
      exp_rfld = {is_wr, is_int, is_int & fr_q[1][7], ra,
                  is_wr ? (op == 8'hC9 ? {fr_q[4], fr_q[5], fr_q[6], fr_q[7]}
                                       : {fr_q[3], fr_q[4], fr_q[5], fr_q[6]}) : 32'h0};
      if (!is_wr) begin
        rs_q.push_back(8'hF0);
        for (int i = 0; i < 4; i++) rs_q.push_back(reg_rdata[8*i +: 8]);
        if (m_crc) begin
          cc = ref_crc16(reg_rdata);
          rs_q.push_back(cc[15:8]);
          rs_q.push_back(cc[7:0]);
        end
      end
    end
    if (ok && (op == 8'hC1 || op == 8'hC2 || op == 8'hC7 || op == 8'hC8)) begin
      exp_dreq = 1;
      exp_dfld = {(op == 8'hC1 || op == 8'hC7), fr_q[1], fr_q[2], fr_q[3],
                  (m_need == 5) ? {8'h00, fr_q[4], fr_q[5]} : {fr_q[4], fr_q[5], fr_q[6]}};
    end
    exp_tx = rs_q.pop_front();
    m_phase = 2;
  endtask

  task automatic model_step(input logic [7:0] b);
    if (m_phase == 0) begin
      fr_q.delete();
      fr_q.push_back(b);
      m_crc = crc_en;
      m_need = fields_of(b);
      m_phase = 1;
    end else if (m_phase == 1) begin
      fr_q.push_back(b);
      if (fr_q.size() == 1 + m_need + (m_crc ? 1 : 0)) model_finish();
    end else begin
      exp_tx = (rs_q.size() > 0) ? rs_q.pop_front() : 8'h00;
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(posedge clk);
    #1;
    model_step(b);
    @(negedge clk);
    rx_valid = 1'b0;
    @(posedge clk);
    #1;
    exp_rreq = 0;
    exp_dreq = 0;
  endtask

  task automatic drop_cs();
    @(negedge clk);
    cs_active = 1'b0;
    @(posedge clk);
    #1;
    m_phase = 0;
    exp_tx = 8'h00;
    rs_q.delete();
    @(negedge clk);
    cs_active = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [7:0] body[$],
                            input bit use_crc, input logic [7:0] crc_flip,
                            input bit flip_mode, input int dummies);
    logic [7:0] q[$];
    crc_en = use_crc;
    q.push_back(op);
    foreach (body[i]) q.push_back(body[i]);
    put_byte(op);
    if (flip_mode) crc_en = !use_crc;
    for (int i = 1; i < q.size(); i++) put_byte(q[i]);
    if (use_crc) put_byte(ref_crc7(q, q.size()) ^ crc_flip);
    for (int i = 0; i < dummies; i++) put_byte(8'hFF);
    drop_cs();
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      chk(tx_byte == exp_tx, cur_req, "tx_byte", 64'(tx_byte), 64'(exp_tx));
      chk(reg_req == exp_rreq, cur_req, "reg_req", 64'(reg_req), 64'(exp_rreq));
      chk(dma_req == exp_dreq, cur_req, "dma_req", 64'(dma_req), 64'(exp_dreq));
      if (exp_rreq)
        chk({reg_we, reg_internal, reg_clockless, reg_addr, (reg_we ? reg_wdata : 32'h0)} == exp_rfld,
            cur_req, "reg fields",
            64'({reg_we, reg_internal, reg_clockless, reg_addr, reg_wdata}), 64'(exp_rfld));
      if (exp_dreq)
        chk({dma_we, dma_addr, dma_len} == exp_dfld, cur_req, "dma fields",
            64'({dma_we, dma_addr, dma_len}), 64'(exp_dfld));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(tx_byte == 8'h00 && !reg_req && !dma_req, "R1", "reset state",
        64'({tx_byte, reg_req, dma_req}), 64'h0);
    cs_active = 1'b1;
    mon_on = 1'b1;

    cur_req = "R2 R3 R8";  // single write, no CRC
    send_frame(8'hC9, '{8'h12, 8'h34, 8'h56, 8'hDE, 8'hAD, 8'hBE, 8'hEF}, 0, 8'h00, 0, 4);

    cur_req = "R4 R8";     // single read, no CRC
    reg_rdata = 32'h11223344;
    send_frame(8'hCA, '{8'hAB, 8'hCD, 8'hEF}, 0, 8'h00, 0, 9);

    cur_req = "R5 R6 R8";  // internal clockless read with CRC
    reg_rdata = 32'hA5C3_0F71;
    send_frame(8'hC4, '{8'h81, 8'h23, 8'h00}, 1, 8'h00, 0, 11);

    cur_req = "R6 R8";     // internal write with CRC
    send_frame(8'hC3, '{8'h10, 8'h2C, 8'h01, 8'h02, 8'h03, 8'h04}, 1, 8'h00, 0, 4);

    cur_req = "R9";        // 2-byte and 3-byte length block transfers
    send_frame(8'hC1, '{8'h00, 8'h40, 8'h10, 8'h01, 8'h80}, 0, 8'h00, 0, 3);
    send_frame(8'hC8, '{8'h7F, 8'hFF, 8'h00, 8'h01, 8'h23, 8'h45}, 1, 8'h00, 0, 3);
    send_frame(8'hC7, '{8'h01, 8'h02, 8'h03, 8'h00, 8'h00, 8'h05}, 0, 8'h00, 0, 3);
    send_frame(8'hC2, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1, 8'h00, 0, 3);

    cur_req = "R6 R7";     // corrupted CRC byte
    send_frame(8'hCA, '{8'h00, 8'h00, 8'h04}, 1, 8'h10, 0, 9);
    send_frame(8'hC9, '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01}, 1, 8'h80, 0, 4);

    cur_req = "R6";        // bit 0 of the CRC byte is ignored
    reg_rdata = 32'h0000_00FF;
    send_frame(8'hCA, '{8'h00, 8'h10, 8'h00}, 1, 8'h01, 0, 11);

    cur_req = "R7";        // unknown opcodes
    send_frame(8'hA5, '{8'h01, 8'h02, 8'h03}, 0, 8'h00, 0, 4);
    send_frame(8'hCB, '{8'h01, 8'h02, 8'h03}, 1, 8'h00, 0, 4);

    cur_req = "R10";       // control opcodes
    send_frame(8'hC5, '{8'h00, 8'h00, 8'h00}, 0, 8'h00, 0, 4);
    send_frame(8'hC6, '{8'h00, 8'h00, 8'h00}, 1, 8'h00, 0, 4);
    send_frame(8'hCF, '{8'hFF, 8'hFF, 8'hFF}, 0, 8'h00, 0, 4);

    cur_req = "R11";       // chip select drop mid-frame, then a clean frame
    crc_en = 1'b0;
    put_byte(8'hC9);
    put_byte(8'h01);
    put_byte(8'h02);
    drop_cs();
    @(negedge clk);
    chk(tx_byte == 8'h00 && !reg_req, "R11", "after drop", 64'({tx_byte, reg_req}), 64'h0);
    reg_rdata = 32'h8765_4321;
    send_frame(8'hCA, '{8'h00, 8'h00, 8'h08}, 0, 8'h00, 0, 8);

    cur_req = "R12";       // crc_en changes after the opcode
    send_frame(8'hC4, '{8'h00, 8'h40, 8'h00}, 1, 8'h00, 1, 11);
    send_frame(8'hCA, '{8'h00, 8'h00, 8'h0C}, 0, 8'h00, 1, 9);

    cur_req = "R13";       // long tail of dummy bytes after a reply
    send_frame(8'hC3, '{8'h00, 8'h04, 8'hCA, 8'hFE, 8'hBA, 8'hBE}, 0, 8'h00, 0, 12);
    @(negedge clk);
    chk(tx_byte == 8'h00, "R13", "parked tx", 64'(tx_byte), 64'h0);

    mon_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule